// File: doc/BRIEF.md
# UART Register Interface

This block is the register and status side of a simple UART as seen from a processor bus. It decodes 32-bit word accesses on a small address window and holds the receive buffer, the transmit holding byte, the interrupt enable, interrupt identification, line control, modem control, line status, modem status and divisor registers. It drives a single level-sensitive interrupt line.

On the serial side it offers the transmit byte through a valid/ready handshake, masked to the word length programmed in line control. After the byte is accepted, a single-cycle `tx_done_i` pulse from the line engine marks the end of the transmission. Received bytes arrive as a byte with a one-cycle valid strobe. Bit timing, the divisor's effect on baud rate, parity and FIFOs belong to the line engine. The divisor is only stored here, and zero means no delay.

Bus accesses complete in the cycle they are presented. Read data and the error flag are combinational. Side effects such as loading registers or clearing status take place at the clock edge that ends the access.

Top module: `uart_regif`

## Requirements
- R1: After reset every register reads zero except line status, which reads 0x20. `irq_o` and `tx_valid_o` are low.
- R2: A legal write to interrupt enable (0x04), line control (0x0C), modem control (0x10), line status (0x14), modem status (0x18) or divisor (0x1C) stores bits [7:0]. A read returns them zero-extended to 32 bits.
- R3: An access with `size_i` other than 4, with `addr_i[1:0]` nonzero, or with an offset of 0x20 or above raises `err_o` in the same cycle and changes no register.
- R4: A write to offset 0x00 does the following:
  - It clears line-status bit 5 and the transmit-ready identification.
  - It raises `tx_valid_o`, which stays high until a cycle with `tx_ready_i` high.
- R5: `tx_data_o` is the transmit byte ANDed with a mask chosen by line-control bits [1:0]: 0 gives 0x1F, 1 gives 0x3F, 2 gives 0x7F and 3 gives 0xFF.
- R6: A `tx_done_i` pulse after the byte was accepted has these effects:
  - It sets line-status bit 5.
  - Interrupt identification then reads 0x2.
  - It raises `irq_o` when interrupt-enable bit 1 is set.
- R7: Writing interrupt enable with bit 1 set, while line-status bit 5 is set, makes identification read 0x2 and raises `irq_o`. Writing it with bits 1 and 0 clear drops `irq_o`.
- R8: An `rx_valid_i` strobe has these effects:
  - It stores `rx_data_i` and sets line-status bit 0.
  - Only when interrupt-enable bit 0 is set does identification read 0x4 and `irq_o` rise.
- R9: A read of offset 0x00 returns the stored receive byte and clears line-status bit 0 and the receive-ready identification.
- R10: With receive and transmit causes both pending, identification reads 0x4. Once the receive cause clears, it reads 0x2.
- R11: A `tx_done_i` pulse while no byte has been accepted for transmission has no effect on line status or identification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access present this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the window |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero-extended register value |
| err_o | output | 1 | Access is illegal (size, alignment or range) |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Line engine accepts the byte |
| tx_data_o | output | 8 | Transmit byte masked to word length |
| tx_done_i | input | 1 | Transmission finished (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit address window and 32-bit data. The wide window lets offsets 0x20 and above reach the out-of-range error path, next to the size and alignment errors. All four word-length settings are driven through the transmit mask. Sequences cover a held-off ready, a stray done pulse, and receive and transmit causes pending together, so the identification priority and the interrupt gating are observed at the ports.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IER  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IIR  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LCR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MCR  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LSR  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MSR  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_DIV  = 3'd7;

  localparam int LSR_RXRDY = 0;
  localparam int LSR_TXE   = 5;
  localparam int IER_RX    = 0;
  localparam int IER_TX    = 1;
  localparam int IIR_TX    = 1;
  localparam int IIR_RX    = 2;

  localparam logic [REG_W-1:0] LSR_RESET = 8'h20;

  typedef enum logic [1:0] {TX_IDLE, TX_OFFER, TX_FLIGHT} tx_state_e;

  function automatic logic [REG_W-1:0] word_mask(input logic [1:0] wlen);
    case (wlen)
      2'd0:    return 8'h1F;
      2'd1:    return 8'h3F;
      2'd2:    return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3,
  parameter int BUS_BYTES = 4
) (
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                err_o
);
  localparam int LSB_W = $clog2(BUS_BYTES);
  localparam int TOP_LSB = LSB_W + IDX_W;

  logic legal;
  logic [IDX_W-1:0] idx;

  assign idx = addr_i[TOP_LSB-1:LSB_W];

  always_comb begin
    legal = (size_i == SIZE_W'(BUS_BYTES)) && (addr_i[LSB_W-1:0] == '0);
    if (addr_i[ADDR_W-1:TOP_LSB] != '0) legal = 1'b0;
  end

  assign err_o = req_i && !legal;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = req_i && legal && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_regif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_data_i,
  input  logic [1:0]       wlen_i,
  input  logic             tx_ready_i,
  input  logic             tx_done_i,
  output logic             tx_valid_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             done_o
);
  tx_state_e state_q, state_d;
  logic [REG_W-1:0] thr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TX_OFFER:  if (tx_ready_i) state_d = TX_FLIGHT;
      TX_FLIGHT: if (tx_done_i) state_d = TX_IDLE;
      default:   state_d = TX_IDLE;
    endcase
    if (load_i) state_d = TX_OFFER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      thr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_i) thr_q <= load_data_i;
    end
  end

  assign tx_valid_o = (state_q == TX_OFFER);
  assign tx_data_o  = thr_q & word_mask(wlen_i);
  assign done_o     = (state_q == TX_FLIGHT) && tx_done_i && !load_i;

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o) else $error("tx hold"); // R4
  AST_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_IDLE) |-> !done_o) else $error("stray done"); // R11
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ier_i,
  input  logic             tx_empty_i,
  input  logic             ier_wr_i,
  input  logic             iir_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             thr_wr_i,
  input  logic             tx_done_i,
  input  logic             rx_evt_i,
  input  logic             rbr_rd_i,
  output logic [REG_W-1:0] iir_o,
  output logic             irq_o
);
  logic tx_pend_q, tx_pend_d, rx_pend_q, rx_pend_d;

  always_comb begin
    tx_pend_d = tx_pend_q;
    if (thr_wr_i) tx_pend_d = 1'b0;
    if (iir_wr_i) tx_pend_d = wdata_i[IIR_TX];
    if (ier_wr_i && wdata_i[IER_TX] && tx_empty_i) tx_pend_d = 1'b1;
    if (tx_done_i) tx_pend_d = 1'b1;

    rx_pend_d = rx_pend_q;
    if (rbr_rd_i) rx_pend_d = 1'b0;
    if (iir_wr_i) rx_pend_d = wdata_i[IIR_RX];
    if (rx_evt_i && ier_i[IER_RX]) rx_pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pend_q <= 1'b0;
      rx_pend_q <= 1'b0;
    end else begin
      tx_pend_q <= tx_pend_d;
      rx_pend_q <= rx_pend_d;
    end
  end

  // receive cause wins the identification code
  always_comb begin
    iir_o = '0;
    if (rx_pend_q)      iir_o[IIR_RX] = 1'b1;
    else if (tx_pend_q) iir_o[IIR_TX] = 1'b1;
  end

  assign irq_o = (rx_pend_q && ier_i[IER_RX]) || (tx_pend_q && ier_i[IER_TX]);

  AST_IIR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(iir_o) <= 1) else $error("iir code"); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (iir_o != '0)) else $error("irq cause"); // R6
  AST_DONE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !iir_wr_i |=> tx_pend_q) else $error("done pend"); // R6
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [REG_W-1:0]  tx_data_o,
  input  logic              tx_done_i,
  input  logic              rx_valid_i,
  input  logic [REG_W-1:0]  rx_data_i,
  output logic              irq_o
);
  localparam int BUS_BYTES = DATA_W / 8;

  logic [NUM_REGS-1:0] sel, wr_sel;
  logic                rd_data;
  logic [REG_W-1:0]    wbyte;
  logic [REG_W-1:0]    rbr_q, ier_q, lcr_q, mcr_q, lsr_q, msr_q, div_q;
  logic [REG_W-1:0]    lsr_d, iir;
  logic                tx_done;
  logic [REG_W-1:0]    view [NUM_REGS];
  logic                unused_wdata;

  assign wbyte        = wdata_i[REG_W-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:REG_W];

  uart_bus_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)
  ) u_dec (
    .req_i(req_i), .addr_i(addr_i), .size_i(size_i), .sel_o(sel), .err_o(err_o)
  );

  assign wr_sel  = we_i ? sel : '0;
  assign rd_data = !we_i && sel[IDX_DATA];

  uart_tx_path u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(wr_sel[IDX_DATA]), .load_data_i(wbyte), .wlen_i(lcr_q[1:0]),
    .tx_ready_i(tx_ready_i), .tx_done_i(tx_done_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .done_o(tx_done)
  );

  uart_irq_ctrl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ier_i(ier_q), .tx_empty_i(lsr_q[LSR_TXE]),
    .ier_wr_i(wr_sel[IDX_IER]), .iir_wr_i(wr_sel[IDX_IIR]), .wdata_i(wbyte),
    .thr_wr_i(wr_sel[IDX_DATA]), .tx_done_i(tx_done),
    .rx_evt_i(rx_valid_i), .rbr_rd_i(rd_data),
    .iir_o(iir), .irq_o(irq_o)
  );

  always_comb begin
    lsr_d = lsr_q;
    if (wr_sel[IDX_LSR])  lsr_d = wbyte;
    if (wr_sel[IDX_DATA]) lsr_d[LSR_TXE] = 1'b0;
    if (rd_data)          lsr_d[LSR_RXRDY] = 1'b0;
    if (tx_done)          lsr_d[LSR_TXE] = 1'b1;
    if (rx_valid_i)       lsr_d[LSR_RXRDY] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q <= '0;
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      lsr_q <= LSR_RESET;
      msr_q <= '0;
      div_q <= '0;
    end else begin
      lsr_q <= lsr_d;
      if (rx_valid_i)      rbr_q <= rx_data_i;
      if (wr_sel[IDX_IER]) ier_q <= wbyte;
      if (wr_sel[IDX_LCR]) lcr_q <= wbyte;
      if (wr_sel[IDX_MCR]) mcr_q <= wbyte;
      if (wr_sel[IDX_MSR]) msr_q <= wbyte;
      if (wr_sel[IDX_DIV]) div_q <= wbyte;
    end
  end

  always_comb begin
    view[IDX_DATA] = rbr_q;
    view[IDX_IER]  = ier_q;
    view[IDX_IIR]  = iir;
    view[IDX_LCR]  = lcr_q;
    view[IDX_MCR]  = mcr_q;
    view[IDX_LSR]  = lsr_q;
    view[IDX_MSR]  = msr_q;
    view[IDX_DIV]  = div_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) rdata_o = DATA_W'(view[i]);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel) && !(err_o && sel != '0)) else $error("sel"); // R3
  AST_ERR_NOWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !rx_valid_i && !tx_done |=> $stable(lsr_q) && $stable(ier_q)) else $error("err"); // R3
  AST_THR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel[IDX_DATA] |=> !lsr_q[LSR_TXE] && tx_valid_o) else $error("thr"); // R4
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> lsr_q[LSR_RXRDY]) else $error("rx"); // R8
  AST_RBR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && !rx_valid_i && !wr_sel[IDX_LSR] |=> !lsr_q[LSR_RXRDY]) else $error("rbr"); // R9
endmodule

// File: tb/tb_uart_regif.sv
module tb_uart_regif;
  localparam logic [7:0] A_DATA = 8'h00, A_IER = 8'h04, A_IIR = 8'h08, A_LCR = 8'h0C,
                         A_MCR = 8'h10, A_LSR = 8'h14, A_MSR = 8'h18, A_DIV = 8'h1C;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [2:0] size = 3'd4;
  logic [31:0] wdata = 0, rdata;
  logic err, tx_valid, tx_ready = 0, tx_done = 0, rx_valid = 0, irq;
  logic [7:0] tx_data, rx_data = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_regif dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_done_i(tx_done), .rx_valid_i(rx_valid), .rx_data_i(rx_data), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] sz, output logic [31:0] rd, output logic e);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; size = sz;
    #5;
    rd = rdata; e = err;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic e;
    access(1'b1, a, d, 3'd4, rd, e);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic e;
    access(1'b0, a, 0, 3'd4, rd, e);
    check(tag, rd, exp);
  endtask

  task automatic tx_accept();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic tx_finish();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    rd_chk("R1 lsr", A_LSR, 32'h20);
    rd_chk("R1 ier", A_IER, 0);
    rd_chk("R1 iir", A_IIR, 0);
    rd_chk("R1 lcr", A_LCR, 0);
    rd_chk("R1 div", A_DIV, 0);
  endtask

  task automatic t_regs();
    wr(A_LCR, 32'hFFFF_FF5A); rd_chk("R2 lcr", A_LCR, 32'h5A);
    wr(A_MCR, 32'h0000_0133); rd_chk("R2 mcr", A_MCR, 32'h33);
    wr(A_MSR, 32'h0000_00C4); rd_chk("R2 msr", A_MSR, 32'hC4);
    wr(A_DIV, 32'h1234_5678); rd_chk("R2 div", A_DIV, 32'h78);
    wr(A_LSR, 32'h0000_0061); rd_chk("R2 lsr", A_LSR, 32'h61);
    wr(A_LSR, 32'h20);
    wr(A_IER, 32'h0000_0000); rd_chk("R2 ier", A_IER, 0);
    wr(A_LCR, 32'h3);
  endtask

  task automatic t_err();
    logic [31:0] rd; logic e;
    access(1'b1, A_LCR, 32'h11, 3'd2, rd, e);
    check("R3 size err", e, 1);
    rd_chk("R3 lcr kept", A_LCR, 32'h3);
    access(1'b0, 8'h20, 0, 3'd4, rd, e);
    check("R3 range err", e, 1);
    access(1'b1, 8'h0D, 32'h0, 3'd4, rd, e);
    check("R3 align err", e, 1);
    rd_chk("R3 lcr kept2", A_LCR, 32'h3);
    access(1'b1, 8'h40, 32'h7, 3'd4, rd, e);
    check("R3 high err", e, 1);
    access(1'b0, A_LCR, 0, 3'd4, rd, e);
    check("R3 legal no err", e, 0);
  endtask

  task automatic t_tx();
    wr(A_DATA, 32'hA5);
    check("R4 valid", tx_valid, 1);
    check("R4 data", tx_data, 8'hA5);
    rd_chk("R4 lsr busy", A_LSR, 32'h00);
    repeat (3) @(negedge clk);
    check("R4 held", tx_valid, 1);
    tx_accept();
    check("R4 dropped", tx_valid, 0);
    rd_chk("R4 still busy", A_LSR, 32'h00);
    tx_finish();
    check("R6 irq off", irq, 0);
    rd_chk("R6 lsr", A_LSR, 32'h20);
    rd_chk("R6 iir", A_IIR, 32'h2);
    wr(A_IIR, 0);
    wr(A_IER, 32'h2);
    check("R7 irq on", irq, 1);
    rd_chk("R7 iir", A_IIR, 32'h2);
    wr(A_IER, 32'h0);
    check("R7 irq off", irq, 0);
  endtask

  task automatic t_mask();
    for (int w = 0; w < 4; w++) begin
      logic [7:0] m;
      m = (w == 0) ? 8'h1F : (w == 1) ? 8'h3F : (w == 2) ? 8'h7F : 8'hFF;
      wr(A_LCR, w);
      wr(A_DATA, 32'hFF);
      check($sformatf("R5 wlen%0d", w), tx_data, m);
      tx_accept();
      tx_finish();
    end
    wr(A_LCR, 32'h3);
  endtask

  task automatic t_tx_irq();
    wr(A_IER, 32'h2);
    check("R6 pre irq", irq, 1);
    wr(A_DATA, 32'h42);
    check("R4 irq cleared", irq, 0);
    tx_accept();
    tx_finish();
    check("R6 irq raised", irq, 1);
    wr(A_IER, 0);
    wr(A_IIR, 0);
  endtask

  task automatic t_stray();
    wr(A_LSR, 32'h00);
    tx_finish();
    rd_chk("R11 lsr", A_LSR, 32'h00);
    rd_chk("R11 iir", A_IIR, 32'h00);
    wr(A_LSR, 32'h20);
  endtask

  task automatic t_rx();
    rx_byte(8'h3C);
    rd_chk("R8 lsr", A_LSR, 32'h21);
    rd_chk("R8 iir off", A_IIR, 0);
    check("R8 irq off", irq, 0);
    rd_chk("R9 data", A_DATA, 32'h3C);
    rd_chk("R9 lsr", A_LSR, 32'h20);
    wr(A_IER, 32'h1);
    rx_byte(8'h81);
    rd_chk("R8 iir", A_IIR, 32'h4);
    check("R8 irq", irq, 1);
    rd_chk("R9 data2", A_DATA, 32'h81);
    check("R9 irq", irq, 0);
    rd_chk("R9 iir", A_IIR, 0);
  endtask

  task automatic t_prio();
    wr(A_IER, 32'h3);
    rx_byte(8'h55);
    rd_chk("R10 both", A_IIR, 32'h4);
    rd_chk("R10 data", A_DATA, 32'h55);
    rd_chk("R10 tx left", A_IIR, 32'h2);
    check("R10 irq", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_err();
    t_tx();
    t_mask();
    t_tx_irq();
    t_stray();
    t_rx();
    t_prio();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule